// File: doc/BRIEF.md
# Calculator Key Scanner

This block sits between a keyboard byte receiver and the rest of a calculator datapath. Each received byte arrives on `code_i` with a one-cycle `strobe_i` pulse. The block keeps only the keys a calculator uses and converts each one into an action:

- A printable key becomes an ASCII character offered to a line-history buffer.
- The erase key becomes a delete-last-character request to that buffer.
- The commit key becomes a request to an expression evaluator.

Each action is carried over a four-phase request/acknowledge handshake. While any handshake is open, incoming bytes are dropped.

Scancodes follow the common set-2 make codes. A break prefix (0xF0) discards the byte that follows it, so key releases produce nothing. An extended prefix (0xE0) qualifies only the byte that follows it. That two-byte pair is how the keypad divide key is recognised.

Top module: `calc_key_scanner`

## Requirements
- R1: While `rst_ni` is low, `take_o`, `bksp_o` and `eval_o` are low immediately, without waiting for a clock edge. Pending break and extended prefix state is cleared, so a byte received after reset is decoded as a plain byte.
- R2: Keypad digit codes map as follows, with `take_o` high:
  - 0x70 gives '0' (0x30).
  - 0x69 gives '1'.
  - 0x72 gives '2'.
  - 0x7A gives '3'.
  - 0x6B gives '4'.
  - 0x73 gives '5'.
  - 0x74 gives '6'.
  - 0x6C gives '7'.
  - 0x75 gives '8'.
  - 0x7D gives '9' (0x39).
- R3: The remaining single-byte printable keys map as follows, with `take_o` high: 0x79 gives '+' (0x2B), 0x7B gives '-' (0x2D), 0x7C gives '*' (0x2A), and 0x29 gives space (0x20).
- R4: The pair 0xE0 then 0x4A gives '/' (0x2F) on `char_o` with `take_o` high. The 0xE0 byte alone raises no request. A 0x4A byte without the prefix raises no request.
- R5: After 0xE0, any byte other than 0x4A is discarded. The prefix applies to one byte only, so the next byte is decoded normally.
- R6: The byte following 0xF0 is discarded whatever its value. Decoding resumes with the byte after it.
- R7: Any byte outside the key set raises no request.
- R8: A character request behaves as follows:
  - `take_o` rises on the clock edge that samples the strobe.
  - `take_o` stays high with a constant `char_o` until `done_i` is sampled high.
  - `take_o` falls on that edge.
  - No further byte is accepted until `done_i` has been sampled low.
- R9: 0x66 raises `bksp_o`, not `take_o`. It follows the same sequence on `done_i` as R8.
- R10: 0x5A raises `eval_o`. `eval_o` is held for as long as `fin_i` stays low, falls on the edge that samples `fin_i` high, and no further byte is accepted until `fin_i` is sampled low.
- R11: A byte strobed while any request or release phase is open is dropped, including prefix bytes.
- R12: At most one of `take_o`, `bksp_o`, `eval_o` is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle marker for a received byte |
| code_i | input | 8 | Received scancode byte |
| char_o | output | 8 | ASCII character for the history buffer |
| take_o | output | 1 | Character request |
| bksp_o | output | 1 | Delete-last-character request |
| done_i | input | 1 | Acknowledge from the history buffer |
| eval_o | output | 1 | Evaluate-line request |
| fin_i | input | 1 | Acknowledge from the evaluator |

## Verification
Every request is one register away from its strobe, so `take_o`, `bksp_o` or `eval_o` is due on the first rising edge that samples the strobe. A request drops on the first edge that samples its acknowledge high. The bench drives each input at a falling edge and reads outputs at the next falling edge, half a period after the edge that must have produced the result. Checks that something is ignored look at the outputs both one cycle after the dropped byte and one cycle after a following byte whose decoding would reveal stale prefix state.

// File: rtl/calc_key_pkg.sv
package calc_key_pkg;
  localparam int CODE_W = 8;
  localparam int CHAR_W = 8;

  localparam logic [CODE_W-1:0] SC_BREAK = 8'hF0;
  localparam logic [CODE_W-1:0] SC_EXT   = 8'hE0;
  localparam logic [CODE_W-1:0] SC_DIV   = 8'h4A;
  localparam logic [CODE_W-1:0] SC_PLUS  = 8'h79;
  localparam logic [CODE_W-1:0] SC_MINUS = 8'h7B;
  localparam logic [CODE_W-1:0] SC_MUL   = 8'h7C;
  localparam logic [CODE_W-1:0] SC_SPACE = 8'h29;
  localparam logic [CODE_W-1:0] SC_ERASE = 8'h66;
  localparam logic [CODE_W-1:0] SC_ENTER = 8'h5A;

  typedef enum logic [1:0] {
    K_NONE,
    K_CHAR,
    K_BKSP,
    K_EVAL
  } key_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHAR,
    ST_BKSP,
    ST_ACK_REL,
    ST_EVAL,
    ST_FIN_REL
  } hs_state_e;
endpackage

// File: rtl/calc_key_prefix.sv
module calc_key_prefix
  import calc_key_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pass_o,
  output logic              ext_o
);
  logic brk_q, ext_q;
  logic is_brk, is_ext;

  assign is_brk = (code_i == SC_BREAK);
  assign is_ext = (code_i == SC_EXT);
  assign pass_o = accept_i && !brk_q && !is_brk && !is_ext;
  assign ext_o  = ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      ext_q <= 1'b0;
    end else if (accept_i) begin
      if (brk_q) begin
        // byte after break is swallowed, both flags retire
        brk_q <= 1'b0;
        ext_q <= 1'b0;
      end else if (is_brk) begin
        brk_q <= 1'b1;
        ext_q <= 1'b0;
      end else if (is_ext) begin
        ext_q <= 1'b1;
      end else begin
        ext_q <= 1'b0;
      end
    end
  end

  AST_EXT_ONE_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q && accept_i && !is_ext && !is_brk |=> !ext_q) // R5
    else $error("extended flag outlived one byte");

  AST_BRK_SWALLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_q && accept_i |=> !brk_q && !ext_q) // R6
    else $error("break flag not retired");
endmodule

// File: rtl/calc_key_decode.sv
module calc_key_decode
  import calc_key_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  output key_kind_e         kind_o,
  output logic [CHAR_W-1:0] ascii_o
);
  always_comb begin
    kind_o  = K_NONE;
    ascii_o = '0;
    if (ext_i) begin
      if (code_i == SC_DIV) begin
        kind_o  = K_CHAR;
        ascii_o = 8'h2F;
      end
    end else begin
      kind_o = K_CHAR;
      case (code_i)
        8'h70: ascii_o = 8'h30;
        8'h69: ascii_o = 8'h31;
        8'h72: ascii_o = 8'h32;
        8'h7A: ascii_o = 8'h33;
        8'h6B: ascii_o = 8'h34;
        8'h73: ascii_o = 8'h35;
        8'h74: ascii_o = 8'h36;
        8'h6C: ascii_o = 8'h37;
        8'h75: ascii_o = 8'h38;
        8'h7D: ascii_o = 8'h39;
        SC_PLUS:  ascii_o = 8'h2B;
        SC_MINUS: ascii_o = 8'h2D;
        SC_MUL:   ascii_o = 8'h2A;
        SC_SPACE: ascii_o = 8'h20;
        SC_ERASE: kind_o  = K_BKSP;
        SC_ENTER: kind_o  = K_EVAL;
        default:  kind_o  = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/calc_key_handshake.sv
module calc_key_handshake
  import calc_key_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  key_kind_e         kind_i,
  input  logic [CHAR_W-1:0] ascii_i,
  input  logic              done_i,
  input  logic              fin_i,
  output logic              idle_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              take_o,
  output logic              bksp_o,
  output logic              eval_o
);
  hs_state_e state_q, state_d;
  logic [CHAR_W-1:0] char_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (fire_i) begin
          case (kind_i)
            K_CHAR:  state_d = ST_CHAR;
            K_BKSP:  state_d = ST_BKSP;
            K_EVAL:  state_d = ST_EVAL;
            default: state_d = ST_IDLE;
          endcase
        end
      end
      ST_CHAR, ST_BKSP: if (done_i) state_d = ST_ACK_REL;
      ST_ACK_REL:       if (!done_i) state_d = ST_IDLE;
      ST_EVAL:          if (fin_i) state_d = ST_FIN_REL;
      ST_FIN_REL:       if (!fin_i) state_d = ST_IDLE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && fire_i && kind_i == K_CHAR) char_q <= ascii_i;
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign char_o = char_q;
  assign take_o = (state_q == ST_CHAR);
  assign bksp_o = (state_q == ST_BKSP);
  assign eval_o = (state_q == ST_EVAL);

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take_o, bksp_o, eval_o})) // R12
    else $error("more than one request high");

  AST_TAKE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !done_i |=> take_o) // R8
    else $error("take dropped before done");

  AST_CHAR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o && !done_i |=> $stable(char_o)) // R8
    else $error("char changed during request");

  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o || bksp_o) && done_i |=> !take_o && !bksp_o) // R9
    else $error("request held after done");

  AST_BKSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bksp_o && !done_i |=> bksp_o) // R9
    else $error("backspace dropped before done");

  AST_EVAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_o && !fin_i |=> eval_o) // R10
    else $error("eval dropped before finished");

  AST_EVAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_o && fin_i |=> !eval_o) // R10
    else $error("eval held after finished");
endmodule

// File: rtl/calc_key_scanner.sv
module calc_key_scanner
  import calc_key_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CHAR_W-1:0] char_o,
  output logic              take_o,
  output logic              bksp_o,
  input  logic              done_i,
  output logic              eval_o,
  input  logic              fin_i
);
  logic              idle, accept, pass, ext;
  key_kind_e         kind;
  logic [CHAR_W-1:0] ascii;

  // bytes arriving during any open handshake are dropped whole
  assign accept = strobe_i && idle;

  calc_key_prefix u_prefix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .code_i   (code_i),
    .pass_o   (pass),
    .ext_o    (ext)
  );

  calc_key_decode u_decode (
    .code_i  (code_i),
    .ext_i   (ext),
    .kind_o  (kind),
    .ascii_o (ascii)
  );

  calc_key_handshake u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (pass),
    .kind_i  (kind),
    .ascii_i (ascii),
    .done_i  (done_i),
    .fin_i   (fin_i),
    .idle_o  (idle),
    .char_o  (char_o),
    .take_o  (take_o),
    .bksp_o  (bksp_o),
    .eval_o  (eval_o)
  );

  AST_REQ_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_o) || $rose(bksp_o) || $rose(eval_o) |-> $past(strobe_i)) // R11
    else $error("request without a strobe");

  AST_BUSY_NO_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle && !take_o && !bksp_o && !eval_o |=> !take_o && !bksp_o && !eval_o) // R8
    else $error("new request during release phase");
endmodule

// File: tb/sim_calc_key_scanner.sv
`timescale 1ns/1ps
module sim_calc_key_scanner;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe_i = 1'b0;
  logic [7:0] code_i = 8'h00;
  logic [7:0] char_o;
  logic       take_o, bksp_o, eval_o;
  logic       done_i = 1'b0;
  logic       fin_i = 1'b0;
  int         n_chk = 0;
  int         n_err = 0;

  always #4 clk_i = ~clk_i;

  calc_key_scanner u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(strobe_i), .code_i(code_i),
    .char_o(char_o), .take_o(take_o), .bksp_o(bksp_o), .done_i(done_i),
    .eval_o(eval_o), .fin_i(fin_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int reqs();
    return {29'd0, take_o, bksp_o, eval_o};
  endfunction

  task automatic send(input logic [7:0] c);
    @(negedge clk_i);
    strobe_i = 1'b1;
    code_i   = c;
    @(negedge clk_i);
    strobe_i = 1'b0;
  endtask

  task automatic expect_quiet(input string tag);
    chk(reqs() == 0, tag, reqs(), 0);
    @(negedge clk_i);
    chk(reqs() == 0, tag, reqs(), 0);
  endtask

  // R8/R9 release: hold, ack, stray byte while done high, release
  task automatic ack_done(input string tag, input int req_bits);
    repeat (3) @(negedge clk_i);
    chk(reqs() == req_bits, {tag, " hold"}, reqs(), req_bits);
    done_i = 1'b1;
    @(negedge clk_i);
    chk(reqs() == 0, {tag, " drop"}, reqs(), 0);
    send(8'h70);
    chk(reqs() == 0, {tag, " R8 locked while done high"}, reqs(), 0);
    done_i = 1'b0;
    @(negedge clk_i);
    chk(reqs() == 0, {tag, " idle"}, reqs(), 0);
  endtask

  task automatic expect_char(input logic [7:0] c, input logic [7:0] a, input string tag);
    send(c);
    chk(take_o && !bksp_o && !eval_o, {tag, " take"}, reqs(), 4);
    chk(char_o == a, {tag, " char"}, char_o, a);
    ack_done(tag, 4);
  endtask

  task automatic t_reset;
    chk(reqs() == 0, "R1 reset", reqs(), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(8'h70);
    chk(take_o == 1'b1, "R1 mid reset setup", take_o, 1);
    #1 rst_ni = 1'b0;
    #1 chk(reqs() == 0, "R1 async clear", reqs(), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(8'hE0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    send(8'h4A);
    expect_quiet("R1 prefix cleared");
    send(8'hF0);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    expect_char(8'h69, 8'h31, "R1 break cleared");
  endtask

  task automatic t_digits;
    logic [7:0] codes [10] = '{8'h70, 8'h69, 8'h72, 8'h7A, 8'h6B,
                               8'h73, 8'h74, 8'h6C, 8'h75, 8'h7D};
    for (int i = 0; i < 10; i++)
      expect_char(codes[i], 8'h30 + 8'(i), $sformatf("R2 digit %0d", i));
  endtask

  task automatic t_ops;
    expect_char(8'h79, 8'h2B, "R3 plus");
    expect_char(8'h7B, 8'h2D, "R3 minus");
    expect_char(8'h7C, 8'h2A, "R3 mul");
    expect_char(8'h29, 8'h20, "R3 space");
  endtask

  task automatic t_divide;
    send(8'hE0);
    expect_quiet("R4 prefix alone");
    expect_char(8'h4A, 8'h2F, "R4 divide");
    send(8'h4A);
    expect_quiet("R4 bare 4A");
  endtask

  task automatic t_ext_other;
    send(8'hE0);
    send(8'h70);
    expect_quiet("R5 ext other dropped");
    expect_char(8'h70, 8'h30, "R5 ext cleared");
  endtask

  task automatic t_break;
    send(8'hF0);
    expect_quiet("R6 break prefix");
    send(8'h70);
    expect_quiet("R6 released key");
    expect_char(8'h72, 8'h32, "R6 resumes");
    send(8'hE0);
    send(8'hF0);
    send(8'h4A);
    expect_quiet("R6 extended release");
    expect_char(8'h7A, 8'h33, "R6 after ext release");
  endtask

  task automatic t_unknown;
    send(8'h1C);
    expect_quiet("R7 letter");
    send(8'h16);
    expect_quiet("R7 top-row digit");
    send(8'h00);
    expect_quiet("R7 zero");
  endtask

  task automatic t_bksp;
    send(8'h66);
    chk(bksp_o && !take_o && !eval_o, "R9 bksp", reqs(), 2);
    ack_done("R9 bksp", 2);
  endtask

  task automatic t_enter;
    send(8'h5A);
    chk(eval_o && !take_o && !bksp_o, "R10 eval", reqs(), 1);
    repeat (20) @(negedge clk_i);
    chk(reqs() == 1, "R10 long wait", reqs(), 1);
    fin_i = 1'b1;
    @(negedge clk_i);
    chk(eval_o == 1'b0, "R10 drop", eval_o, 0);
    send(8'h70);
    chk(reqs() == 0, "R10 locked while fin high", reqs(), 0);
    fin_i = 1'b0;
    @(negedge clk_i);
    chk(reqs() == 0, "R10 idle", reqs(), 0);
    expect_char(8'h75, 8'h38, "R10 next accepted");
  endtask

  task automatic t_busy;
    send(8'h70);
    chk(take_o && char_o == 8'h30, "R11 first", char_o, 8'h30);
    send(8'h69);
    chk(char_o == 8'h30, "R11 char kept", char_o, 8'h30);
    send(8'hE0);
    send(8'hF0);
    chk(take_o == 1'b1, "R11 still pending", take_o, 1);
    ack_done("R11 release", 4);
    expect_quiet("R11 nothing queued");
    send(8'h4A);
    expect_quiet("R11 prefix dropped");
    expect_char(8'h69, 8'h31, "R11 break dropped");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_digits();
    t_ops();
    t_divide();
    t_ext_other();
    t_break();
    t_unknown();
    t_bksp();
    t_enter();
    t_busy();
    repeat (2) @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule